// File: doc/BRIEF.md
# Grouped carry-select adder with increment-by-one converters

This block adds two unsigned operands and a carry-in and produces the sum and the carry-out. It has no clock or state: the result follows the inputs combinationally. The operand width is split into 4-bit groups. The lowest group is a plain ripple-carry adder fed by the external carry-in. Every higher group computes only one ripple result, the one that assumes its incoming carry is 0. It then derives the result for an incoming carry of 1 by adding one to that value in a small converter. The carry leaving the group below picks one of the two candidates and its matching carry.

The converter needs only XOR gates and a short AND chain. A second ripple adder would need a full adder per bit. The converter therefore saves area and switching activity, and its depth grows only slowly with the group width. The block is meant for datapaths that need a wide adder, such as the accumulation stages of a transposed-form FIR filter.

Top module: `csa_bec_adder`

## Requirements
- R1: `sum_o` equals the low W bits of `a_i + b_i + cin_i`, with both operands treated as unsigned, for every input combination.
- R2: `cout_o` equals bit W (the carry beyond the top bit) of `a_i + b_i + cin_i`.
- R3: The external carry-in enters the lowest group directly. With both operands zero, `sum_o` equals `cin_i` in bit 0 and zero elsewhere, and `cout_o` is 0.
- R4: All-ones plus zero with `cin_i` = 1 wraps to a sum of zero with `cout_o` = 1. Every higher group must then select its increment-by-one result.
- R5: All-ones plus one with `cin_i` = 0 gives a sum of zero and `cout_o` = 1. A carry produced in the lowest group passes through every higher group.
- R6: A group whose candidate sum for incoming carry 0 is all ones produces a carry when its incoming carry is 1. With `a_i` = 0x0000_00F0, `b_i` = 0x0000_000F and `cin_i` = 1 at 32 bits, the sum is 0x0000_0100.
- R7: A group whose incoming carry is 0 passes its ripple result unchanged. Operands that produce no carry at any group boundary give the bitwise OR of the operands.
- R8: The width W is a parameter and must be a multiple of 4. R1 and R2 hold for a two-group instance (W = 8) and for an eight-group instance (W = 32).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | W | First operand, unsigned |
| b_i | input | W | Second operand, unsigned |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | W | Low W bits of the sum |
| cout_o | output | 1 | Carry out of bit W-1 |

## Verification
The 8-bit instance is swept over every pair of operands with both carry-in values. This exercises every combination of incoming carry and candidate sum at the single group boundary, including the case where the converter wraps from 1111 to 0000 and must raise the carry. The 32-bit instance receives random operands together with directed patterns. The all-ones wrap, from the carry-in and from b = 1, shows whether a carry reaches the top through seven selections. Patterns with no carry show whether the ripple candidate passes through untouched. A carry placed at one boundary with an all-ones group above it tells whether the converter's carry term is formed correctly.

// File: rtl/csa_pkg.sv
package csa_pkg;
    localparam int unsigned GRP_W = 4;

    typedef struct packed {
        logic [GRP_W-1:0] sum;
        logic             cy;
    } grp_res_t;
endpackage

// File: rtl/csa_rca_group.sv
module csa_rca_group #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] x_i,
    input  logic [N-1:0] y_i,
    input  logic         ci_i,
    output logic [N-1:0] s_o,
    output logic         co_o
);
    logic [N:0] chain;

    assign chain[0] = ci_i;

    for (genvar k = 0; k < N; k++) begin : g_fa
        assign s_o[k]       = x_i[k] ^ y_i[k] ^ chain[k];
        assign chain[k+1]   = (x_i[k] & y_i[k]) | (chain[k] & (x_i[k] ^ y_i[k]));
    end

    assign co_o = chain[N];
endmodule

// File: rtl/csa_inc_conv.sv
module csa_inc_conv #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] v_i,
    input  logic         vc_i,
    output logic [N-1:0] w_o,
    output logic         wc_o
);
    logic [N:0] all_ones;

    assign all_ones[0] = 1'b1;

    for (genvar k = 0; k < N; k++) begin : g_bit
        assign w_o[k]        = v_i[k] ^ all_ones[k];
        assign all_ones[k+1] = all_ones[k] & v_i[k];
    end

    assign wc_o = vc_i | all_ones[N];
endmodule

// File: rtl/csa_group_sel.sv
module csa_group_sel
    import csa_pkg::*;
(
    input  grp_res_t zero_i,
    input  grp_res_t one_i,
    input  logic     sel_i,
    output grp_res_t pick_o
);
    always_comb begin
        if (sel_i) pick_o = one_i;
        else       pick_o = zero_i;
    end
endmodule

// File: rtl/csa_bec_adder.sv
module csa_bec_adder
    import csa_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    localparam int unsigned NGRP = W / GRP_W;

    if ((W % GRP_W) != 0 || W == 0) begin : g_bad_width
        $error("width must be a positive multiple of 4");
    end

    logic [NGRP:0] grp_cy;

    assign grp_cy[0] = cin_i;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        if (g == 0) begin : g_low
            csa_rca_group #(.N(GRP_W)) rca_i (
                .x_i (a_i[GRP_W-1:0]),
                .y_i (b_i[GRP_W-1:0]),
                .ci_i(grp_cy[0]),
                .s_o (sum_o[GRP_W-1:0]),
                .co_o(grp_cy[1])
            );
        end else begin : g_high
            grp_res_t cand0, cand1, pick;

            csa_rca_group #(.N(GRP_W)) rca_i (
                .x_i (a_i[g*GRP_W +: GRP_W]),
                .y_i (b_i[g*GRP_W +: GRP_W]),
                .ci_i(1'b0),
                .s_o (cand0.sum),
                .co_o(cand0.cy)
            );

            csa_inc_conv #(.N(GRP_W)) conv_i (
                .v_i (cand0.sum),
                .vc_i(cand0.cy),
                .w_o (cand1.sum),
                .wc_o(cand1.cy)
            );

            csa_group_sel sel_i (
                .zero_i(cand0),
                .one_i (cand1),
                .sel_i (grp_cy[g]),
                .pick_o(pick)
            );

            assign sum_o[g*GRP_W +: GRP_W] = pick.sum;
            assign grp_cy[g+1]             = pick.cy;
        end
    end

    assign cout_o = grp_cy[NGRP];
endmodule

// File: rtl/csa_bec_adder_chk.sv
module csa_bec_adder_chk #(
    parameter int unsigned W = 32
) (
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic         cin_i,
    input logic [W-1:0] sum_o,
    input logic         cout_o
);
    logic [W:0] ref_full;

    always_comb begin
        ref_full = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
        if (!$isunknown({a_i, b_i, cin_i, sum_o, cout_o})) begin
            p_sum_r1: assert (sum_o == ref_full[W-1:0])
                else $error("R1 sum mismatch");
            p_cout_r2: assert (cout_o == ref_full[W])
                else $error("R2 carry-out mismatch");
            if (a_i == '0 && b_i == '0) begin
                p_cin_low_r3: assert (sum_o == {{(W-1){1'b0}}, cin_i} && !cout_o)
                    else $error("R3 carry-in not at bit 0");
            end
            if (&a_i && b_i == '0 && cin_i) begin
                p_wrap_r4: assert (sum_o == '0 && cout_o)
                    else $error("R4 wrap failed");
            end
        end
    end
endmodule

bind csa_bec_adder csa_bec_adder_chk #(.W(W)) chk_i (
    .a_i   (a_i),
    .b_i   (b_i),
    .cin_i (cin_i),
    .sum_o (sum_o),
    .cout_o(cout_o)
);

// File: tb/csa_bec_adder_tb.sv
module csa_bec_adder_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [7:0]  a8, b8, s8;
    logic        c8, co8;
    logic [31:0] a32, b32, s32;
    logic        c32, co32;

    csa_bec_adder #(.W(8)) dut_i (
        .a_i(a8), .b_i(b8), .cin_i(c8), .sum_o(s8), .cout_o(co8)
    );

    csa_bec_adder #(.W(32)) dut32_i (
        .a_i(a32), .b_i(b32), .cin_i(c32), .sum_o(s32), .cout_o(co32)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run32(input string req, input logic [31:0] a, input logic [31:0] b,
                         input logic ci);
        logic [32:0] e;
        a32 = a; b32 = b; c32 = ci;
        #1;
        e = {1'b0, a} + {1'b0, b} + {32'd0, ci};
        check({req, " sum"}, {32'd0, s32}, {32'd0, e[31:0]});
        check({req, " cout"}, {63'd0, co32}, {63'd0, e[32]});
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 60000 && !done) begin
                bad++; total++;
                $display("FAIL watchdog actual=%0d expected<=60000", cyc);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        a8 = '0; b8 = '0; c8 = 1'b0;
        a32 = '0; b32 = '0; c32 = 1'b0;
        @(negedge clk);
        check("R3 zero inputs sum", {56'd0, s8}, 64'd0);
        check("R3 zero inputs cout", {63'd0, co8}, 64'd0);

        // R1 R2 R8: exhaustive two-group sweep
        for (int ci = 0; ci < 2; ci++) begin
            for (int a = 0; a < 256; a++) begin
                for (int b = 0; b < 256; b++) begin
                    int e;
                    a8 = 8'(a); b8 = 8'(b); c8 = ci[0];
                    #1;
                    e = a + b + ci;
                    check("R1 8-bit sum", {56'd0, s8}, 64'(e & 255));
                    check("R2 8-bit cout", {63'd0, co8}, 64'((e >> 8) & 1));
                end
            end
        end

        run32("R3 cin only", 32'h0, 32'h0, 1'b1);
        check("R3 cin at bit0", {32'd0, s32}, 64'd1);
        run32("R4 all-ones+cin", 32'hFFFF_FFFF, 32'h0, 1'b1);
        check("R4 wrap zero", {32'd0, s32, 31'd0, co32} , {32'd0, 32'd0, 31'd0, 1'b1});
        run32("R5 all-ones+1", 32'hFFFF_FFFF, 32'h1, 1'b0);
        check("R5 carry through", {63'd0, co32}, 64'd1);
        run32("R6 boundary carry", 32'h0000_00F0, 32'h0000_000F, 1'b1);
        check("R6 sum value", {32'd0, s32}, 64'h100);
        run32("R7 no carries", 32'h0F0F_0F0F, 32'h3030_3030, 1'b0);
        check("R7 ripple pass", {32'd0, s32}, 64'h3F3F_3F3F);
        run32("R8 top group", 32'h8000_0000, 32'h8000_0000, 1'b0);

        // R1 R2 R8: random 32-bit vectors
        for (int i = 0; i < 4000; i++) begin
            run32("R1 R2 random32", $urandom, $urandom, 1'($urandom));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule